// File: doc/BRIEF.md
# Multi-Channel FIFO Latency Aligner

This block equalizes the data-path latency of up to four channels. Each channel has its own clock-crossing FIFO and reports three measurements, all taken against a shared reference strobe. The first is its latency in sample periods. The second is a marker counter value. The third is the word slot in which the marker shows up at the FIFO output. A mask says which channels take part. On a compute request, the block takes the largest latency among the enabled channels as the common target. It then gives each enabled channel the delay it must add to reach that target. The delay is given in sample periods and also split into whole FIFO words plus a leftover number of samples, using a per-channel rate factor.

Before the offsets are used, the block checks whether the measurements can be trusted. A marker slot that falls outside the configured FIFO word width marks that channel as a likely FIFO underflow or overflow. If the marker counter values of the enabled channels spread wider than a programmable tolerance, a flag is raised. The block also runs a free-running meter that counts sample clocks between successive rising edges of the reference strobe. The meter falls back to zero when the strobe stops. All results are captured together and are announced by a one-cycle done pulse.

Top module: `lat_aligner`

## Requirements
- R1: Bit i of `chan_en` enables channel i. A channel whose bit is 0 takes no part in the target, the spread check or the marker check. After a compute, its `delay_out` field, `word_out` field, `rem_out` field and `slot_err` bit are all 0.
- R2: After a compute, `target_lat` equals the largest `lat_in` value among the enabled channels. It is 0 when no channel is enabled.
- R3: After a compute, each enabled channel i has `delay_out` field i (bits i*LAT_W upward) equal to `target_lat` minus its own latency. A channel that holds the largest latency therefore gets 0.
- R4: For each enabled channel, `word_out` field i is its delay divided by its rate factor, and `rem_out` field i is the remainder of that division. The rate factor is `rate_in` field i, and a factor of 0 is treated as 1.
- R5: Bit i of `slot_err` is 1 after a compute when channel i is enabled and its `slot_in` value is equal to or greater than `fifo_words`.
- R6: `spread_err` is 1 after a compute when at least one channel is enabled and the maximum minus the minimum `mark_in` value over the enabled channels is strictly greater than `spread_tol`.
- R7: The strobe meter counts the sample-clock cycles between two successive rising edges of `ref_strobe`. For example, edges sampled 384 cycles apart give 384. After a compute, the latest such count appears on `strobe_period`.
- R8: If no rising edge of `ref_strobe` arrives within TIMEOUT cycles after the previous one, the measured period becomes 0. The next edge only restarts the measurement and leaves the period at 0.
- R9: `done` is high for exactly the one cycle after the cycle in which `calc_req` is high. All result outputs change only at that same edge and hold their values otherwise.
- R10: After a synchronous reset, `done`, `target_lat`, `strobe_period`, `spread_err`, `slot_err` and all offset fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| calc_req | input | 1 | Compute request, sampled every cycle |
| chan_en | input | NCH | Channel enable mask |
| fifo_words | input | SLOT_W | FIFO width in words; a marker slot at or above this value is an error |
| spread_tol | input | MARK_W | Allowed marker counter spread |
| lat_in | input | NCH*LAT_W | Per-channel latency in sample periods |
| mark_in | input | NCH*MARK_W | Per-channel marker counter value |
| slot_in | input | NCH*SLOT_W | Per-channel marker word slot |
| rate_in | input | NCH*RATE_W | Per-channel samples per FIFO word (0 counts as 1) |
| ref_strobe | input | 1 | Shared reference strobe, synchronous to clk |
| done | output | 1 | One-cycle pulse: results updated |
| target_lat | output | LAT_W | Common target latency |
| delay_out | output | NCH*LAT_W | Per-channel delay in sample periods |
| word_out | output | NCH*LAT_W | Per-channel delay in whole FIFO words |
| rem_out | output | NCH*RATE_W | Per-channel leftover samples |
| slot_err | output | NCH | Per-channel marker slot out of range |
| spread_err | output | 1 | Marker counter spread above tolerance |
| strobe_period | output | PER_W | Measured strobe period in sample clocks |

## Verification
The timeout path of the strobe meter is the hardest case to reach from the ports. The strobe must first produce a valid measurement, then stay low for more than TIMEOUT cycles. A later single edge must then leave the result at zero instead of reporting a huge gap. The bench gets there by generating two edges a known distance apart and checking the count. It then holds the strobe low past the limit, computes again and expects 0. Finally it sends one lone edge and expects 0 once more. The divider corner is covered by a separate scenario, in which a rate factor of zero must behave like one.

// File: rtl/lat_align_pkg.sv
package lat_align_pkg;

    localparam int NCH_DEF     = 4;
    localparam int LAT_W_DEF   = 12;
    localparam int MARK_W_DEF  = 8;
    localparam int SLOT_W_DEF  = 6;
    localparam int RATE_W_DEF  = 4;
    localparam int PER_W_DEF   = 16;
    localparam int TIMEOUT_DEF = 4096;

    typedef enum logic {
        MS_IDLE  = 1'b0,
        MS_ARMED = 1'b1
    } meter_st_t;

    typedef struct packed {
        logic any_en;
        logic over_tol;
    } spread_t;

    function automatic int unsigned eff_rate(input int unsigned r);
        return (r == 0) ? 1 : r;
    endfunction

endpackage

// File: rtl/lat_strobe_meter.sv
module lat_strobe_meter
    import lat_align_pkg::*;
#(
    parameter int TIMEOUT = TIMEOUT_DEF,
    parameter int PER_W   = PER_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    output logic [PER_W-1:0] period
);
    localparam int CNT_W = $clog2(TIMEOUT + 1);

    meter_st_t        st;
    logic [CNT_W-1:0] cnt;
    logic             prev;
    logic             rise;

    assign rise = strobe && !prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= MS_IDLE;
            cnt    <= '0;
            prev   <= 1'b0;
            period <= '0;
        end else begin
            prev <= strobe;
            if (rise) begin
                cnt <= CNT_W'(1);
                if (st == MS_ARMED) period <= PER_W'(cnt);
                st <= MS_ARMED;
            end else if (st == MS_ARMED) begin
                if (cnt == CNT_W'(TIMEOUT)) begin
                    period <= '0;
                    st     <= MS_IDLE;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end

    // R8
    idle_count_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (st == MS_IDLE && !rise) |=> $stable(cnt));

endmodule

// File: rtl/lat_extreme.sv
module lat_extreme #(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic [N*W-1:0] vals,
    input  logic [N-1:0]   en,
    output logic [W-1:0]   max_v,
    output logic [W-1:0]   min_v
);
    always_comb begin
        max_v = '0;
        min_v = '1;
        for (int i = 0; i < N; i++) begin
            if (en[i]) begin
                if (vals[i*W +: W] > max_v) max_v = vals[i*W +: W];
                if (vals[i*W +: W] < min_v) min_v = vals[i*W +: W];
            end
        end
    end
endmodule

// File: rtl/lat_chan_offset.sv
module lat_chan_offset
    import lat_align_pkg::*;
#(
    parameter int LAT_W  = LAT_W_DEF,
    parameter int SLOT_W = SLOT_W_DEF,
    parameter int RATE_W = RATE_W_DEF
) (
    input  logic              en,
    input  logic [LAT_W-1:0]  lat,
    input  logic [LAT_W-1:0]  target,
    input  logic [SLOT_W-1:0] slot,
    input  logic [SLOT_W-1:0] fifo_words,
    input  logic [RATE_W-1:0] rate,
    output logic [LAT_W-1:0]  delay,
    output logic [LAT_W-1:0]  words,
    output logic [RATE_W-1:0] rem,
    output logic              slot_bad
);
    logic [LAT_W-1:0] f_eff;
    logic [LAT_W-1:0] rem_full;

    assign f_eff    = LAT_W'(eff_rate(32'(rate)));
    assign delay    = en ? (target - lat) : '0;
    assign words    = delay / f_eff;
    assign rem_full = delay % f_eff;
    assign rem      = rem_full[RATE_W-1:0];
    assign slot_bad = en && (slot >= fifo_words);
endmodule

// File: rtl/lat_aligner.sv
module lat_aligner
    import lat_align_pkg::*;
#(
    parameter int NCH     = NCH_DEF,
    parameter int LAT_W   = LAT_W_DEF,
    parameter int MARK_W  = MARK_W_DEF,
    parameter int SLOT_W  = SLOT_W_DEF,
    parameter int RATE_W  = RATE_W_DEF,
    parameter int PER_W   = PER_W_DEF,
    parameter int TIMEOUT = TIMEOUT_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  calc_req,
    input  logic [NCH-1:0]        chan_en,
    input  logic [SLOT_W-1:0]     fifo_words,
    input  logic [MARK_W-1:0]     spread_tol,
    input  logic [NCH*LAT_W-1:0]  lat_in,
    input  logic [NCH*MARK_W-1:0] mark_in,
    input  logic [NCH*SLOT_W-1:0] slot_in,
    input  logic [NCH*RATE_W-1:0] rate_in,
    input  logic                  ref_strobe,
    output logic                  done,
    output logic [LAT_W-1:0]      target_lat,
    output logic [NCH*LAT_W-1:0]  delay_out,
    output logic [NCH*LAT_W-1:0]  word_out,
    output logic [NCH*RATE_W-1:0] rem_out,
    output logic [NCH-1:0]        slot_err,
    output logic                  spread_err,
    output logic [PER_W-1:0]      strobe_period
);
    logic [LAT_W-1:0]      lat_max, lat_min_unused;
    logic [MARK_W-1:0]     mark_max, mark_min;
    logic [PER_W-1:0]      period_live;
    logic [NCH*LAT_W-1:0]  delay_c, words_c;
    logic [NCH*RATE_W-1:0] rem_c;
    logic [NCH-1:0]        slot_c;
    logic [NCH-1:0]        en_q;
    spread_t               spr;

    lat_extreme #(.N(NCH), .W(LAT_W)) u_lat_ext (
        .vals(lat_in), .en(chan_en), .max_v(lat_max), .min_v(lat_min_unused)
    );

    lat_extreme #(.N(NCH), .W(MARK_W)) u_mark_ext (
        .vals(mark_in), .en(chan_en), .max_v(mark_max), .min_v(mark_min)
    );

    lat_strobe_meter #(.TIMEOUT(TIMEOUT), .PER_W(PER_W)) u_meter (
        .clk(clk), .rst(rst), .strobe(ref_strobe), .period(period_live)
    );

    assign spr.any_en   = |chan_en;
    assign spr.over_tol = (mark_max - mark_min) > spread_tol;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        lat_chan_offset #(.LAT_W(LAT_W), .SLOT_W(SLOT_W), .RATE_W(RATE_W)) u_off (
            .en        (chan_en[g]),
            .lat       (lat_in[g*LAT_W +: LAT_W]),
            .target    (lat_max),
            .slot      (slot_in[g*SLOT_W +: SLOT_W]),
            .fifo_words(fifo_words),
            .rate      (rate_in[g*RATE_W +: RATE_W]),
            .delay     (delay_c[g*LAT_W +: LAT_W]),
            .words     (words_c[g*LAT_W +: LAT_W]),
            .rem       (rem_c[g*RATE_W +: RATE_W]),
            .slot_bad  (slot_c[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done          <= 1'b0;
            en_q          <= '0;
            target_lat    <= '0;
            delay_out     <= '0;
            word_out      <= '0;
            rem_out       <= '0;
            slot_err      <= '0;
            spread_err    <= 1'b0;
            strobe_period <= '0;
        end else begin
            done <= calc_req;
            if (calc_req) begin
                en_q          <= chan_en;
                target_lat    <= lat_max;
                delay_out     <= delay_c;
                word_out      <= words_c;
                rem_out       <= rem_c;
                slot_err      <= slot_c;
                spread_err    <= spr.any_en && spr.over_tol;
                strobe_period <= period_live;
            end
        end
    end

    logic [NCH-1:0] zero_hit;
    for (genvar g = 0; g < NCH; g++) begin : g_hit
        assign zero_hit[g] = en_q[g] && (delay_out[g*LAT_W +: LAT_W] == '0);
    end

    // R9
    done_after_req_chk: assert property (@(posedge clk) disable iff (rst)
        calc_req |=> done);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        !calc_req |=> (!done && $stable(target_lat) && $stable(delay_out) && $stable(strobe_period)));

    // R2
    target_reached_chk: assert property (@(posedge clk) disable iff (rst)
        (done && en_q != '0) |-> (zero_hit != '0));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R3
        offset_sum_chk: assert property (@(posedge clk) disable iff (rst)
            (done && en_q[g]) |->
            ((LAT_W+1)'(delay_out[g*LAT_W +: LAT_W]) + (LAT_W+1)'($past(lat_in[g*LAT_W +: LAT_W])))
                == (LAT_W+1)'(target_lat));

        // R1
        idle_chan_chk: assert property (@(posedge clk) disable iff (rst)
            (done && !en_q[g]) |->
            (delay_out[g*LAT_W +: LAT_W] == '0 && word_out[g*LAT_W +: LAT_W] == '0 && !slot_err[g]));

        // R4
        word_split_chk: assert property (@(posedge clk) disable iff (rst)
            done |->
            ((2*LAT_W)'(word_out[g*LAT_W +: LAT_W]) *
                 (2*LAT_W)'(eff_rate(32'($past(rate_in[g*RATE_W +: RATE_W]))))
             + (2*LAT_W)'(rem_out[g*RATE_W +: RATE_W])
             == (2*LAT_W)'(delay_out[g*LAT_W +: LAT_W])));
    end

endmodule

// File: tb/sim_lat_aligner.sv
`timescale 1ns/1ps
module sim_lat_aligner;
    localparam int NCH = 4, LAT_W = 12, MARK_W = 8, SLOT_W = 6, RATE_W = 4, PER_W = 16;
    localparam int TIMEOUT = 4096;

    logic clk = 1'b0, rst = 1'b1, calc_req = 1'b0, ref_strobe = 1'b0;
    logic [NCH-1:0] chan_en = '0;
    logic [SLOT_W-1:0] fifo_words = '0;
    logic [MARK_W-1:0] spread_tol = '0;
    logic [LAT_W-1:0] lat [NCH];
    logic [MARK_W-1:0] mark [NCH];
    logic [SLOT_W-1:0] slot [NCH];
    logic [RATE_W-1:0] rate [NCH];
    logic [NCH*LAT_W-1:0] lat_in;
    logic [NCH*MARK_W-1:0] mark_in;
    logic [NCH*SLOT_W-1:0] slot_in;
    logic [NCH*RATE_W-1:0] rate_in;
    logic done, spread_err;
    logic [LAT_W-1:0] target_lat;
    logic [NCH*LAT_W-1:0] delay_out, word_out;
    logic [NCH*RATE_W-1:0] rem_out;
    logic [NCH-1:0] slot_err;
    logic [PER_W-1:0] strobe_period;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            lat_in[i*LAT_W +: LAT_W]    = lat[i];
            mark_in[i*MARK_W +: MARK_W] = mark[i];
            slot_in[i*SLOT_W +: SLOT_W] = slot[i];
            rate_in[i*RATE_W +: RATE_W] = rate[i];
        end
    end

    lat_aligner u0 (
        .clk(clk), .rst(rst), .calc_req(calc_req), .chan_en(chan_en),
        .fifo_words(fifo_words), .spread_tol(spread_tol), .lat_in(lat_in),
        .mark_in(mark_in), .slot_in(slot_in), .rate_in(rate_in),
        .ref_strobe(ref_strobe), .done(done), .target_lat(target_lat),
        .delay_out(delay_out), .word_out(word_out), .rem_out(rem_out),
        .slot_err(slot_err), .spread_err(spread_err), .strobe_period(strobe_period)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Issue a request; return at the negedge where done must be high.
    task automatic compute;
        @(negedge clk) calc_req = 1'b1;
        @(negedge clk) calc_req = 1'b0;
        chk("R9", "done pulse", int'(done), 1);
    endtask

    // Reference model of all channel results, from the requirements.
    task automatic check_results(input string req, input int exp_period);
        int tgt = 0, mx = 0, mn = 255, any = 0;
        for (int i = 0; i < NCH; i++) if (chan_en[i]) begin
            any = 1;
            if (int'(lat[i]) > tgt) tgt = int'(lat[i]);
            if (int'(mark[i]) > mx) mx = int'(mark[i]);
            if (int'(mark[i]) < mn) mn = int'(mark[i]);
        end
        chk(req, "target", int'(target_lat), tgt);
        for (int i = 0; i < NCH; i++) begin
            int d, f;
            d = chan_en[i] ? tgt - int'(lat[i]) : 0;
            f = (rate[i] == 0) ? 1 : int'(rate[i]);
            chk(req, $sformatf("delay ch%0d", i), int'(delay_out[i*LAT_W +: LAT_W]), d);
            chk(req, $sformatf("words ch%0d", i), int'(word_out[i*LAT_W +: LAT_W]), d / f);
            chk(req, $sformatf("rem ch%0d", i), int'(rem_out[i*RATE_W +: RATE_W]), d % f);
            chk(req, $sformatf("slot_err ch%0d", i), int'(slot_err[i]),
                int'(chan_en[i] && (slot[i] >= fifo_words)));
        end
        chk(req, "spread_err", int'(spread_err), int'(any && ((mx - mn) > int'(spread_tol))));
        if (exp_period >= 0) chk(req, "period", int'(strobe_period), exp_period);
    endtask

    task automatic set_chan(input int i, input int l, input int m, input int s, input int r);
        lat[i] = LAT_W'(l); mark[i] = MARK_W'(m); slot[i] = SLOT_W'(s); rate[i] = RATE_W'(r);
    endtask

    task automatic t_reset;
        for (int i = 0; i < NCH; i++) set_chan(i, 0, 0, 0, 1);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10", "done", int'(done), 0);
        chk("R10", "target", int'(target_lat), 0);
        chk("R10", "delays", int'(delay_out != '0), 0);
        chk("R10", "period", int'(strobe_period), 0);
        chk("R10", "flags", int'({slot_err, spread_err} != '0), 0);
    endtask

    task automatic t_basic;   // R2 R3 all enabled, one channel short
        chan_en = 4'hF; fifo_words = 12; spread_tol = 2;
        set_chan(0, 108, 9, 8, 1);  set_chan(1, 116, 10, 4, 1);
        set_chan(2, 116, 10, 4, 1); set_chan(3, 116, 10, 4, 1);
        compute();
        check_results("R3", -1);
        chk("R2", "target basic", int'(target_lat), 116);
        chk("R3", "max ch gets 0", int'(delay_out[LAT_W +: LAT_W]), 0);
        @(negedge clk);
        chk("R9", "done drops", int'(done), 0);
        lat[0] = 50;
        repeat (3) @(negedge clk);
        chk("R9", "hold delay ch0", int'(delay_out[0 +: LAT_W]), 8);
    endtask

    task automatic t_mask;    // R1: disabled max channel ignored
        chan_en = 4'b0101; fifo_words = 12; spread_tol = 0;
        set_chan(0, 30, 5, 3, 2); set_chan(1, 900, 200, 40, 3);
        set_chan(2, 45, 5, 11, 4); set_chan(3, 700, 0, 63, 1);
        compute();
        check_results("R1", -1);
        chk("R1", "target ignores ch1", int'(target_lat), 45);
        chk("R1", "slot_err masked", int'(slot_err), 0);
    endtask

    task automatic t_none;    // R2 empty mask
        chan_en = 4'b0000;
        compute();
        check_results("R2", -1);
        chk("R2", "empty target", int'(target_lat), 0);
    endtask

    task automatic t_rate;    // R4 word split incl. factor 0
        chan_en = 4'hF; fifo_words = 16; spread_tol = 10;
        set_chan(0, 100, 1, 0, 8); set_chan(1, 77, 1, 0, 0);
        set_chan(2, 91, 1, 0, 3); set_chan(3, 100, 1, 0, 15);
        compute();
        check_results("R4", -1);
        chk("R4", "rate0 words", int'(word_out[LAT_W +: LAT_W]), 23);
        chk("R4", "rate3 rem", int'(rem_out[2*RATE_W +: RATE_W]), 0);
        chk("R4", "rate8 words", int'(word_out[0 +: LAT_W]), 0);
    endtask

    task automatic t_slot;    // R5 boundary at fifo_words
        chan_en = 4'hF; fifo_words = 12; spread_tol = 10;
        set_chan(0, 10, 3, 11, 1); set_chan(1, 10, 3, 12, 1);
        set_chan(2, 10, 3, 14, 1); set_chan(3, 10, 3, 0, 1);
        compute();
        check_results("R5", -1);
        chk("R5", "slot_err vector", int'(slot_err), 'b0110);
    endtask

    task automatic t_spread;  // R6 boundary at tolerance
        chan_en = 4'hF; fifo_words = 12;
        set_chan(0, 10, 9, 1, 1); set_chan(1, 10, 12, 1, 1);
        set_chan(2, 10, 10, 1, 1); set_chan(3, 10, 11, 1, 1);
        spread_tol = 3; compute();
        chk("R6", "spread equal tol", int'(spread_err), 0);
        spread_tol = 2; compute();
        chk("R6", "spread over tol", int'(spread_err), 1);
        chan_en = 4'b0110; compute();
        check_results("R6", -1);
        chk("R6", "spread masked", int'(spread_err), 0);
    endtask

    task automatic rise_pair(input int gap);
        @(negedge clk) ref_strobe = 1'b1;
        @(negedge clk) ref_strobe = 1'b0;
        repeat (gap - 2) @(negedge clk);
        @(negedge clk) ref_strobe = 1'b1;
        @(negedge clk) ref_strobe = 1'b0;
    endtask

    task automatic t_period;  // R7 R8
        rise_pair(384);
        compute();
        chk("R7", "period 384", int'(strobe_period), 384);
        rise_pair(100);
        compute();
        chk("R7", "period 100", int'(strobe_period), 100);
        repeat (TIMEOUT + 20) @(negedge clk);
        compute();
        chk("R8", "timeout period", int'(strobe_period), 0);
        @(negedge clk) ref_strobe = 1'b1;
        @(negedge clk) ref_strobe = 1'b0;
        repeat (10) @(negedge clk);
        compute();
        chk("R8", "lone edge keeps 0", int'(strobe_period), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_basic();
        t_mask();
        t_none();
        t_rate();
        t_slot();
        t_spread();
        t_period();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule